// File: doc/BRIEF.md
# Multi-Lane SPI Byte Shifter

This block is the bit engine of a serial-flash master. Each request moves one byte across one, two or four data lanes. The caller picks a lane mode, a direction and a byte, then pulses start. The shifter generates the serial clock, places outgoing bits on the lanes and samples incoming bits. It ends the transfer with a one-cycle done pulse and the captured byte. Chip select, command framing and clock-rate selection belong to the level above. That level keeps chip select asserted across the bytes of one command.

Each of the four data pins has its own output-enable. The enable pattern follows from the mode and direction of the most recent accepted transfer, so the pad ring can turn a lane around between bytes. The serial clock idles low. Each half period lasts `HALF_CYCLES` system clocks.

Top module: `spi_lane_shifter`

## Requirements
- R1: After reset, `sclk_o`, `busy_o`, `done_o` and `rx_byte_o` are zero and `dat_oe_o` is 4'b1101, the single-lane transmit pattern.
- R2: Mode code 0 (single) with `dir_rx_i`=0 sends `tx_byte_i` MSB first on lane 0 (`dat_o[0]`) over 8 serial clocks. Lane outputs change only while `sclk_o` is low.
- R3: In single mode with `dir_rx_i`=1, lane 0 carries 1 on every clock, so the line sends 0xFF. The byte is assembled MSB first from lane 1 (`dat_i[1]`), and each bit is sampled in the last system cycle of the `sclk_o` high phase.
- R4: Mode code 1 (dual) uses 4 clocks. Bits 7 and 6 go out first, then 5 and 4, and so on. The higher bit of each pair travels on lane 1 and the lower on lane 0, in both directions.
- R5: Mode code 2 (quad) uses 2 clocks, upper nibble first. Nibble bit n travels on lane n, in both directions.
- R6: Bit n of `dat_oe_o` enables lane n. Single mode gives 4'b1101 in either direction. Dual gives 4'b1111 for transmit and 4'b1100 for receive. Quad gives 4'b1111 for transmit and 4'b0000 for receive. In single and dual modes, lanes 2 and 3 are driven high.
- R7: `dat_oe_o` changes only on the edge that accepts a transfer. It holds while busy and keeps the last pattern after done.
- R8: `sclk_o` is low when idle. Each clock has `HALF_CYCLES` system cycles low and then `HALF_CYCLES` high. `busy_o` lasts exactly 2·`HALF_CYCLES`·(8/lanes) cycles.
- R9: `done_o` is high for one cycle, on the cycle `busy_o` falls. `rx_byte_o` shows the captured byte from then until the next transfer ends.
- R10: A start pulse while busy is ignored. The running byte completes unchanged and yields a single done.
- R11: A start with mode code 3 is ignored. The block stays idle and the lane enables do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request one byte transfer (taken only when idle) |
| mode_i | input | 2 | Lane mode: 0 single, 1 dual, 2 quad, 3 reserved |
| dir_rx_i | input | 1 | 1 = receive, 0 = transmit |
| tx_byte_i | input | 8 | Byte to send |
| dat_i | input | 4 | Sampled level of the four data pins |
| sclk_o | output | 1 | Serial clock, idles low |
| dat_o | output | 4 | Output value of the four data pins |
| dat_oe_o | output | 4 | Per-lane output enable |
| rx_byte_o | output | 8 | Last captured byte |
| done_o | output | 1 | One-cycle end-of-byte pulse |
| busy_o | output | 1 | Transfer in progress |

## Verification
The following properties are checked on every cycle:
- The lane enables stay frozen during a transfer.
- Lane data stays still while the serial clock is high.
- The clock is low whenever the block is idle.
- Done is a single cycle that ends busy.
- A start is refused when the block is busy or the mode code is reserved.

Some behaviour can only be shown by the bench scenarios: the bit-to-lane ordering in each mode, the 0xFF filler on single-lane receive, the exact clock count and transfer length, and the enable pattern for each mode and direction. For these, a slave model drives known bytes and a scoreboard compares the results.

// File: rtl/spi_lane_pkg.sv
`timescale 1ns/1ps
package spi_lane_pkg;
  localparam int BYTE_W = 8;
  localparam int LANE_N = 4;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {
    LM_SINGLE = 2'd0,
    LM_DUAL   = 2'd1,
    LM_QUAD   = 2'd2,
    LM_RSVD   = 2'd3
  } lane_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  typedef struct packed {
    lane_mode_e mode;
    logic       rx;
  } xfer_cfg_t;

  // bits moved per serial clock
  function automatic int step_of(lane_mode_e m);
    case (m)
      LM_DUAL: return 2;
      LM_QUAD: return 4;
      default: return 1;
    endcase
  endfunction

  function automatic int clocks_of(lane_mode_e m);
    return BYTE_W / step_of(m);
  endfunction

  // whether lane l is driven for a given configuration
  function automatic logic lane_drives(xfer_cfg_t c, int l);
    case (c.mode)
      LM_SINGLE: return (l != 1);
      LM_DUAL:   return (!c.rx) || (l >= 2);
      LM_QUAD:   return !c.rx;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/spi_rst_sync.sv
`timescale 1ns/1ps
module spi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/spi_half_timer.sv
`timescale 1ns/1ps
module spi_half_timer #(
  parameter int HALF_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          tick;

  assign tick = run_i && (cnt_q == LAST);

  always_comb begin
    if (!run_i || tick) cnt_d = '0;
    else                cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = tick;
endmodule

// File: rtl/spi_lane_map.sv
`timescale 1ns/1ps
module spi_lane_map
  import spi_lane_pkg::*;
(
  input  xfer_cfg_t         cfg_i,
  input  logic [BYTE_W-1:0] tx_sh_i,
  input  logic [BYTE_W-1:0] rx_sh_i,
  input  logic [LANE_N-1:0] dat_i,
  output logic [LANE_N-1:0] dat_o,
  output logic [LANE_N-1:0] dat_oe_o,
  output logic [BYTE_W-1:0] rx_next_o
);
  // outgoing lanes and incoming assembly
  always_comb begin
    case (cfg_i.mode)
      LM_DUAL: begin
        dat_o     = {2'b11, tx_sh_i[BYTE_W-1], tx_sh_i[BYTE_W-2]};
        rx_next_o = {rx_sh_i[BYTE_W-3:0], dat_i[1], dat_i[0]};
      end
      LM_QUAD: begin
        dat_o     = tx_sh_i[BYTE_W-1 -: LANE_N];
        rx_next_o = {rx_sh_i[BYTE_W-LANE_N-1:0], dat_i};
      end
      default: begin
        dat_o     = {2'b11, 1'b0, tx_sh_i[BYTE_W-1]};
        rx_next_o = {rx_sh_i[BYTE_W-2:0], dat_i[1]};
      end
    endcase
  end

  for (genvar l = 0; l < LANE_N; l++) begin : g_oe
    assign dat_oe_o[l] = lane_drives(cfg_i, l);
  end
endmodule

// File: rtl/spi_shift_ctrl.sv
`timescale 1ns/1ps
module spi_shift_ctrl
  import spi_lane_pkg::*;
#(
  parameter int HALF_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic              dir_rx_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic [BYTE_W-1:0] rx_next_i,
  output xfer_cfg_t         cfg_o,
  output logic [BYTE_W-1:0] tx_sh_o,
  output logic [BYTE_W-1:0] rx_sh_o,
  output logic              sclk_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rx_byte_o
);
  phase_e            phase_q, phase_d;
  xfer_cfg_t         cfg_q, cfg_d;
  logic              cfg_en;
  logic [BYTE_W-1:0] tx_sh_q, tx_sh_d;
  logic [BYTE_W-1:0] rx_sh_q, rx_sh_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              done_q, done_d;
  logic [BYTE_W-1:0] rxb_q;
  logic              rxb_en;
  logic              tick;
  logic              running;
  lane_mode_e        req_mode;
  logic              accept;

  assign running  = (phase_q != PH_IDLE);
  assign req_mode = lane_mode_e'(mode_i);
  assign accept   = !running && start_i && (req_mode != LM_RSVD);

  spi_half_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (running),
    .tick_o (tick)
  );

  always_comb begin
    phase_d = phase_q;
    cfg_d   = cfg_q;
    cfg_en  = 1'b0;
    tx_sh_d = tx_sh_q;
    rx_sh_d = rx_sh_q;
    left_d  = left_q;
    done_d  = 1'b0;
    rxb_en  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          phase_d = PH_LOW;
          cfg_en  = 1'b1;
          cfg_d   = '{mode: req_mode, rx: dir_rx_i};
          tx_sh_d = (dir_rx_i && (req_mode == LM_SINGLE)) ? {BYTE_W{1'b1}} : tx_byte_i;
          rx_sh_d = '0;
          left_d  = CNT_W'(clocks_of(req_mode));
        end
      end
      PH_LOW: begin
        if (tick) phase_d = PH_HIGH;
      end
      PH_HIGH: begin
        if (tick) begin
          rx_sh_d = rx_next_i;
          tx_sh_d = tx_sh_q << step_of(cfg_q.mode);
          left_d  = left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
            rxb_en  = 1'b1;
          end else begin
            phase_d = PH_LOW;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      left_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      tx_sh_q <= tx_sh_d;
      rx_sh_q <= rx_sh_d;
      left_q  <= left_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '{mode: LM_SINGLE, rx: 1'b0};
    else if (cfg_en) cfg_q <= cfg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rxb_q <= '0;
    else if (rxb_en) rxb_q <= rx_next_i;
  end

  assign cfg_o     = cfg_q;
  assign tx_sh_o   = tx_sh_q;
  assign rx_sh_o   = rx_sh_q;
  assign sclk_o    = (phase_q == PH_HIGH);
  assign busy_o    = running;
  assign done_o    = done_q;
  assign rx_byte_o = rxb_q;
endmodule

// File: rtl/spi_lane_shifter.sv
`timescale 1ns/1ps
module spi_lane_shifter
  import spi_lane_pkg::*;
#(
  parameter int HALF_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic              dir_rx_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic [LANE_N-1:0] dat_i,
  output logic              sclk_o,
  output logic [LANE_N-1:0] dat_o,
  output logic [LANE_N-1:0] dat_oe_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              done_o,
  output logic              busy_o
);
  logic              rst_sync_n;
  xfer_cfg_t         cfg;
  logic [BYTE_W-1:0] tx_sh;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] rx_next;

  spi_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  spi_shift_ctrl #(.HALF_CYCLES(HALF_CYCLES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_i   (start_i),
    .mode_i    (mode_i),
    .dir_rx_i  (dir_rx_i),
    .tx_byte_i (tx_byte_i),
    .rx_next_i (rx_next),
    .cfg_o     (cfg),
    .tx_sh_o   (tx_sh),
    .rx_sh_o   (rx_sh),
    .sclk_o    (sclk_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .rx_byte_o (rx_byte_o)
  );

  spi_lane_map u_map (
    .cfg_i     (cfg),
    .tx_sh_i   (tx_sh),
    .rx_sh_i   (rx_sh),
    .dat_i     (dat_i),
    .dat_o     (dat_o),
    .dat_oe_o  (dat_oe_o),
    .rx_next_o (rx_next)
  );
endmodule

// File: rtl/spi_lane_shifter_chk.sv
`timescale 1ns/1ps
module spi_lane_shifter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [1:0] mode_i,
  input logic       sclk_o,
  input logic [3:0] dat_o,
  input logic [3:0] dat_oe_o,
  input logic       done_o,
  input logic       busy_o
);
  AST_OE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(dat_oe_o)); // R7

  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && sclk_o) |-> $stable(dat_o)); // R2

  AST_SCLK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sclk_o); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o))); // R9

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !done_o) |=> (busy_o || done_o)); // R10

  AST_RSVD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && (mode_i == 2'd3)) |=> (!busy_o && $stable(dat_oe_o))); // R11
endmodule

bind spi_lane_shifter spi_lane_shifter_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .mode_i   (mode_i),
  .sclk_o   (sclk_o),
  .dat_o    (dat_o),
  .dat_oe_o (dat_oe_o),
  .done_o   (done_o),
  .busy_o   (busy_o)
);

// File: tb/spi_lane_shifter_tb_top.sv
`timescale 1ns/1ps
module spi_lane_shifter_tb_top;
  localparam int HALF = 2;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [1:0] mode_i;
  logic       dir_rx_i;
  logic [7:0] tx_byte_i;
  logic [3:0] dat_i;
  logic       sclk_o;
  logic [3:0] dat_o;
  logic [3:0] dat_oe_o;
  logic [7:0] rx_byte_o;
  logic       done_o;
  logic       busy_o;

  spi_lane_shifter #(.HALF_CYCLES(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .dir_rx_i(dir_rx_i), .tx_byte_i(tx_byte_i), .dat_i(dat_i),
    .sclk_o(sclk_o), .dat_o(dat_o), .dat_oe_o(dat_oe_o),
    .rx_byte_o(rx_byte_o), .done_o(done_o), .busy_o(busy_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    logic [1:0] mode;
    logic       rx;
    logic       line_chk;
    logic [7:0] exp_line;
    logic [7:0] exp_rx;
    logic [3:0] exp_oe;
  } item_t;

  item_t sb_q[$];
  int n_tests = 0;
  int n_fail  = 0;
  bit ended   = 0;

  // slave model state
  logic [1:0] act_mode = 2'd0;
  logic [7:0] slave_b  = 8'h00;
  int         k        = 0;
  logic [7:0] cap      = 8'h00;
  int         rises    = 0;
  int         cyc      = 0;
  bit         oe_bad   = 0;
  bit         hi_bad   = 0;
  logic       prev_sclk = 1'b0;

  function automatic logic [3:0] chunk(logic [1:0] m, logic [7:0] b, int idx);
    case (m)
      2'd0: return (idx < 8) ? {2'b00, b[7-idx], 1'b0} : 4'h0;
      2'd1: return (idx < 4) ? {2'b00, b[7-2*idx], b[6-2*idx]} : 4'h0;
      2'd2: return (idx == 0) ? b[7:4] : ((idx == 1) ? b[3:0] : 4'h0);
      default: return 4'h0;
    endcase
  endfunction

  assign dat_i = chunk(act_mode, slave_b, k);

  function automatic logic [3:0] oe_expect(logic [1:0] m, logic rx);
    case (m)
      2'd0: return 4'b1101;
      2'd1: return rx ? 4'b1100 : 4'b1111;
      default: return rx ? 4'b0000 : 4'b1111;
    endcase
  endfunction

  function automatic string req_of(logic [1:0] m, logic rx);
    if (m == 2'd0) return rx ? "R3" : "R2";
    if (m == 2'd1) return "R4";
    return "R5";
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      if (sb_q.size() > 0) begin
        if (busy_o) cyc++;
        if (sclk_o && !prev_sclk) begin
          rises++;
          case (sb_q[0].mode)
            2'd0: cap = {cap[6:0], dat_o[0]};
            2'd1: cap = {cap[5:0], dat_o[1:0]};
            default: cap = {cap[3:0], dat_o};
          endcase
          if (dat_oe_o != sb_q[0].exp_oe) oe_bad = 1;
          if (sb_q[0].mode != 2'd2 && dat_o[3:2] != 2'b11) hi_bad = 1;
        end
        if (!sclk_o && prev_sclk) k++;
      end
      prev_sclk = sclk_o;
      if (done_o) begin
        if (sb_q.size() == 0) begin
          check(0, "R10", "unexpected done", 1, 0);
        end else begin
          item_t it;
          int ncl;
          it  = sb_q.pop_front();
          ncl = (it.mode == 2'd0) ? 8 : ((it.mode == 2'd1) ? 4 : 2);
          check(rx_byte_o == it.exp_rx, req_of(it.mode, it.rx), "received byte",
                rx_byte_o, it.exp_rx);
          if (it.line_chk)
            check(cap == it.exp_line, req_of(it.mode, it.rx), "line byte",
                  cap, it.exp_line);
          check(rises == ncl, "R8", "serial clock count", rises, ncl);
          check(cyc == 2*HALF*ncl, "R8", "busy length", cyc, 2*HALF*ncl);
          check(!oe_bad, "R6", "lane enables during transfer", dat_oe_o, it.exp_oe);
          check(!hi_bad, "R6", "lanes 2/3 high", 0, 0);
        end
        k = 0; cap = 8'h00; rises = 0; cyc = 0; oe_bad = 0; hi_bad = 0;
      end
    end
  end

  task automatic xfer(logic [1:0] m, logic rx, logic [7:0] txb, logic [7:0] sb, int inject_at);
    item_t it;
    int t;
    it.mode     = m;
    it.rx       = rx;
    it.line_chk = (!rx) || (m == 2'd0);
    it.exp_line = (rx && m == 2'd0) ? 8'hFF : txb;
    it.exp_rx   = sb;
    it.exp_oe   = oe_expect(m, rx);
    sb_q.push_back(it);
    act_mode  = m;
    slave_b   = sb;
    mode_i    = m;
    dir_rx_i  = rx;
    tx_byte_i = txb;
    start_i   = 1'b1;
    @(negedge clk);
    start_i   = 1'b0;
    t = 0;
    while (!done_o && t < 200) begin
      t++;
      if (inject_at != 0 && t == inject_at) begin
        // R10: competing request during the transfer
        mode_i = 2'd0; dir_rx_i = 1'b0; tx_byte_i = ~txb; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    @(negedge clk);
    check(done_o == 1'b0, "R9", "done width", done_o, 0);
    check(rx_byte_o == sb, "R9", "byte held after done", rx_byte_o, sb);
    check(dat_oe_o == oe_expect(m, rx), "R7", "enables kept after done",
          dat_oe_o, oe_expect(m, rx));
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mode_i = 2'd0; dir_rx_i = 1'b0; tx_byte_i = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(sclk_o == 0 && busy_o == 0 && done_o == 0, "R1", "idle controls",
          {sclk_o, busy_o, done_o}, 0);
    check(dat_oe_o == 4'b1101, "R1", "reset enables", dat_oe_o, 4'b1101);
    check(rx_byte_o == 8'h00, "R1", "reset byte", rx_byte_o, 0);

    xfer(2'd0, 1'b0, 8'hA5, 8'h3C, 0);   // R2
    xfer(2'd0, 1'b1, 8'h00, 8'h96, 0);   // R3
    xfer(2'd1, 1'b0, 8'h4B, 8'hD2, 0);   // R4 transmit
    xfer(2'd1, 1'b1, 8'h00, 8'h87, 0);   // R4 receive
    xfer(2'd2, 1'b0, 8'h3C, 8'hE1, 0);   // R5 transmit
    xfer(2'd2, 1'b1, 8'h00, 8'h5A, 0);   // R5 receive
    xfer(2'd0, 1'b0, 8'h00, 8'hFF, 0);   // R2 boundary pattern
    xfer(2'd2, 1'b0, 8'hC3, 8'h18, 3);   // R10 start while busy
    repeat (40) @(negedge clk);
    check(busy_o == 0, "R10", "no second transfer", busy_o, 0);

    // R11 reserved mode code
    begin
      logic [3:0] oe_before;
      oe_before = dat_oe_o;
      mode_i = 2'd3; dir_rx_i = 1'b1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o == 0, "R11", "reserved start busy", busy_o, 0);
      repeat (2*HALF*8 + 4) @(negedge clk);
      check(busy_o == 0 && sclk_o == 0, "R11", "reserved stays idle", {busy_o, sclk_o}, 0);
      check(dat_oe_o == oe_before, "R11", "reserved enables", dat_oe_o, oe_before);
    end

    xfer(2'd1, 1'b0, 8'h69, 8'h00, 0);   // R6 enable turnaround after quad
    repeat (5) @(negedge clk);
    summary();
  end
endmodule